// File: doc/BRIEF.md
# USB Device Interrupt Aggregator

This block gathers eight event sources from a USB device controller core and presents them to a local microcontroller on a single active-low interrupt line. Each source has a raw pending flag. The core sets the flag with a one-cycle pulse, and firmware clears it by writing a 1 to the matching bit. A per-cause enable mask gates which pending flags can drive the interrupt line. Firmware reads a masked status view to find which enabled cause fired.

The setup-ready cause needs extra care. If a second setup packet completes while the first one is still pending, firmware is probably in the middle of reading stale setup bytes. The block records this "renewed" condition and refuses the next write-1 clear of the setup-ready flag. The interrupt therefore stays asserted, and firmware knows to re-read the setup data. The following clear then succeeds.

The register interface is a plain strobe interface. A write is one cycle with `wrEn` high. The read data is combinational from the selected register.

Top module: `usb_irq_agg`

## Requirements
- R1: A synchronous active-high reset leaves all pending flags at 0 and all enable bits at 0, and holds `intrN` at 1.
- R2: A pulse on `evtPulse[i]` sets pending flag i, which is visible on the clock edge that samples the pulse. Several causes may pulse together.
- R3: A write with `wrAddr`=0 clears every pending flag whose `wrData` bit is 1. Pending flags whose `wrData` bit is 0 keep their value.
- R4: When an event pulse and a write-1 clear hit the same flag in the same cycle, the flag ends up set. This holds for every cause.
- R5: A write with `wrAddr`=1 loads the enable mask from `wrData`. The new mask governs status and `intrN` from the cycle after the write.
- R6: `rdSel`=0 returns the raw pending flags, `rdSel`=1 returns the enable mask, `rdSel`=2 returns pending AND enable, and `rdSel`=3 returns 0.
- R7: `intrN` is 0 exactly when at least one cause is both pending and enabled. With the mask at 0, `intrN` is 1 whatever is pending.
- R8: A setup-ready pulse that arrives while setup-ready is already pending arms a renewal. The next write-1 to bit 0 leaves the flag set and disarms the renewal, and a later write-1 to bit 0 clears it. A pulse in the same cycle as that write does not arm a renewal.
- R9: Bit positions in all three views follow the cause order: 0 setup ready, 1 EP0 receive, 2 EP0 transmit, 3 EP1, 4 EP2, 5 EP3 transmit, 6 bus reset, 7 suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evtPulse | input | 8 | One-cycle event pulses from the controller core, one per cause |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | Write target: 0 pending (write-1 clear), 1 enable mask |
| wrData | input | 8 | Write data |
| rdSel | input | 2 | Read select: 0 pending, 1 enable, 2 masked status, 3 zero |
| rdData | output | 8 | Combinational read data |
| intrN | output | 1 | Active-low interrupt to the microcontroller |

## Verification
Every flag and mask register updates on the edge that samples the pulse or write strobe. The bench therefore drives stimulus on a falling edge, lets one rising edge pass, and checks all three read views and `intrN` at the following falling edge. Read data and `intrN` are combinational from those registers. After `rdSel` changes, the bench waits one nanosecond before it samples them, which keeps every sample well clear of the rising edge. The renewal sequence is checked at each write, so the refused clear and the successful clear each land on their own expected cycle.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

  localparam int NUM_CAUSES = 8;
  localparam int RD_SEL_W   = 2;

  // Cause positions; bit order is visible to firmware.
  localparam int CAUSE_SETUP   = 0;
  localparam int CAUSE_EP0_RX  = 1;
  localparam int CAUSE_EP0_TX  = 2;
  localparam int CAUSE_EP1     = 3;
  localparam int CAUSE_EP2     = 4;
  localparam int CAUSE_EP3_TX  = 5;
  localparam int CAUSE_BUS_RST = 6;
  localparam int CAUSE_SUSPEND = 7;

  typedef enum logic {
    WR_PENDING = 1'b0,
    WR_ENABLE  = 1'b1
  } wrTarget_e;

  typedef enum logic [RD_SEL_W-1:0] {
    RD_PENDING = 2'd0,
    RD_ENABLE  = 2'd1,
    RD_STATUS  = 2'd2,
    RD_NONE    = 2'd3
  } rdTarget_e;

  typedef struct packed {
    logic [NUM_CAUSES-1:0] clrMask;
    logic                  enLoad;
    logic [NUM_CAUSES-1:0] enValue;
  } irqStrobes_t;

endpackage

// File: rtl/usb_irq_ctrl.sv
module usb_irq_ctrl
  import usb_irq_pkg::*;
#(
  parameter int N = NUM_CAUSES
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic        wrAddr,
  input  logic [N-1:0] wrData,
  input  logic        setupEvt,
  input  logic        setupPending,
  output irqStrobes_t strobes,
  output logic        setupRenewed
);

  logic pendWrite;
  logic clrAttempt0;
  logic renewedQ;

  assign pendWrite   = wrEn && (wrAddr == WR_PENDING);
  assign clrAttempt0 = pendWrite && wrData[CAUSE_SETUP];

  always_comb begin
    strobes.clrMask = pendWrite ? wrData : '0;
    if (renewedQ) strobes.clrMask[CAUSE_SETUP] = 1'b0;
    strobes.enLoad  = wrEn && (wrAddr == WR_ENABLE);
    strobes.enValue = wrData;
  end

  // Renewal: a fresh setup packet while the old one is pending blocks one clear.
  always_ff @(posedge clk) begin
    if (rst)                              renewedQ <= 1'b0;
    else if (clrAttempt0)                 renewedQ <= 1'b0;
    else if (setupEvt && setupPending)    renewedQ <= 1'b1;
  end

  assign setupRenewed = renewedQ;

  // R8
  renew_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
    renewedQ |-> setupPending);

  // R8
  renew_disarm_chk: assert property (@(posedge clk) disable iff (rst)
    clrAttempt0 |=> !renewedQ);

endmodule

// File: rtl/usb_irq_datapath.sv
module usb_irq_datapath
  import usb_irq_pkg::*;
#(
  parameter int N = NUM_CAUSES
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        evtPulse,
  input  irqStrobes_t         strobes,
  input  logic [RD_SEL_W-1:0] rdSel,
  output logic [N-1:0]        pending,
  output logic [N-1:0]        enable,
  output logic [N-1:0]        rdData,
  output logic                intrN
);

  logic [N-1:0] status;

  for (genvar g = 0; g < N; g++) begin : gPend
    always_ff @(posedge clk) begin
      if (rst)                         pending[g] <= 1'b0;
      else if (evtPulse[g])            pending[g] <= 1'b1;
      else if (strobes.clrMask[g])     pending[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 enable <= '0;
    else if (strobes.enLoad) enable <= strobes.enValue;
  end

  assign status = pending & enable;
  assign intrN  = ~|status;

  always_comb begin
    case (rdTarget_e'(rdSel))
      RD_PENDING: rdData = pending;
      RD_ENABLE:  rdData = enable;
      RD_STATUS:  rdData = status;
      default:    rdData = '0;
    endcase
  end

  // R2 R4
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (evtPulse != '0) |=> ((pending & $past(evtPulse)) == $past(evtPulse)));

  // R3
  clear_done_chk: assert property (@(posedge clk) disable iff (rst)
    ((strobes.clrMask & ~evtPulse) != '0) |=>
      ((pending & $past(strobes.clrMask & ~evtPulse)) == '0));

  // R3
  quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.clrMask == '0 && evtPulse == '0) |=> $stable(pending));

  // R5
  enable_load_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.enLoad |=> (enable == $past(strobes.enValue)));

  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (enable == '0) |-> intrN);

endmodule

// File: rtl/usb_irq_agg.sv
module usb_irq_agg
  import usb_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_CAUSES-1:0] evtPulse,
  input  logic                  wrEn,
  input  logic                  wrAddr,
  input  logic [NUM_CAUSES-1:0] wrData,
  input  logic [RD_SEL_W-1:0]   rdSel,
  output logic [NUM_CAUSES-1:0] rdData,
  output logic                  intrN
);

  irqStrobes_t           strobes;
  logic [NUM_CAUSES-1:0] pending;
  logic [NUM_CAUSES-1:0] enable;
  logic                  setupRenewed;

  usb_irq_ctrl #(.N(NUM_CAUSES)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .wrEn         (wrEn),
    .wrAddr       (wrAddr),
    .wrData       (wrData),
    .setupEvt     (evtPulse[CAUSE_SETUP]),
    .setupPending (pending[CAUSE_SETUP]),
    .strobes      (strobes),
    .setupRenewed (setupRenewed)
  );

  usb_irq_datapath #(.N(NUM_CAUSES)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .evtPulse (evtPulse),
    .strobes  (strobes),
    .rdSel    (rdSel),
    .pending  (pending),
    .enable   (enable),
    .rdData   (rdData),
    .intrN    (intrN)
  );

  // R8
  setup_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (setupRenewed && wrEn && wrAddr == WR_PENDING && wrData[CAUSE_SETUP])
      |=> pending[CAUSE_SETUP]);

endmodule

// File: tb/usb_irq_agg_tb.sv
`timescale 1ns/1ps
module usb_irq_agg_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] evtPulse = '0;
  logic       wrEn = 1'b0;
  logic       wrAddr = 1'b0;
  logic [7:0] wrData = '0;
  logic [1:0] rdSel = '0;
  logic [7:0] rdData;
  logic       intrN;

  int vecCount = 0;
  int failCount = 0;
  logic [7:0] mPend = '0;
  logic [7:0] mEn = '0;
  logic       mRen = 1'b0;

  usb_irq_agg u_dut (
    .clk(clk), .rst(rst), .evtPulse(evtPulse), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdData), .intrN(intrN)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare all views with the model (called at a falling edge).
  task automatic checkAll(input string req);
    rdSel = 2'd0; #1; chk({req, " pending"}, rdData, mPend);
    rdSel = 2'd1; #1; chk({req, " enable"},  rdData, mEn);
    rdSel = 2'd2; #1; chk({req, " status"},  rdData, mPend & mEn);
    rdSel = 2'd3; #1; chk({req, " R6 zero"}, rdData, 8'h00);
    chk({req, " R7 intrN"}, {7'b0, intrN}, {7'b0, ~|(mPend & mEn)});
  endtask

  // One clock of stimulus; returns at the next falling edge.
  task automatic cyc(input logic [7:0] evt, input logic we, input logic wa, input logic [7:0] wd);
    logic [7:0] clr;
    logic att0;
    evtPulse = evt; wrEn = we; wrAddr = wa; wrData = wd;
    @(posedge clk);
    clr = (we && !wa) ? wd : 8'h00;
    if (mRen) clr[0] = 1'b0;
    att0 = we && !wa && wd[0];
    mRen = att0 ? 1'b0 : ((evt[0] && mPend[0]) ? 1'b1 : mRen);
    mPend = evt | (mPend & ~clr);
    if (we && wa) mEn = wd;
    @(negedge clk);
    evtPulse = '0; wrEn = 1'b0; wrAddr = 1'b0; wrData = '0;
  endtask

  initial begin
    #1500000;
    failCount++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    checkAll("R1");

    // R2 R9: each cause alone lands on its own bit; mask off keeps intrN high
    for (int i = 0; i < 8; i++) begin
      cyc(8'h01 << i, 1'b0, 1'b0, 8'h00);
      chk("R9 single cause bit", mPend, 8'h01 << i);
      checkAll("R2");
      cyc(8'h00, 1'b1, 1'b0, 8'hFF);
      checkAll("R3");
    end

    // R5 R6 R7: sweep all pending patterns against several masks
    for (int p = 0; p < 256; p++) begin
      cyc(p[7:0], 1'b0, 1'b0, 8'h00);
      checkAll("R2");
      cyc(8'h00, 1'b1, 1'b1, {p[3:0], p[7:4]});
      checkAll("R5");
      cyc(8'h00, 1'b1, 1'b1, 8'hFF);
      checkAll("R7");
      cyc(8'h00, 1'b1, 1'b1, 8'h00);
      checkAll("R7 masked");
      // R3: partial clear, then zero write must change nothing
      cyc(8'h00, 1'b1, 1'b0, p[7:0] ^ 8'hA5);
      checkAll("R3 partial");
      cyc(8'h00, 1'b1, 1'b0, 8'h00);
      checkAll("R3 zero write");
      cyc(8'h00, 1'b1, 1'b0, 8'hFF);
    end

    // R4: set and clear on the same bit in the same cycle, each cause
    cyc(8'h00, 1'b1, 1'b1, 8'hFF);
    for (int i = 0; i < 8; i++) begin
      cyc(8'h00, 1'b1, 1'b0, 8'hFF);
      cyc(8'h01 << i, 1'b1, 1'b0, 8'hFF);
      chk("R4 set wins", mPend, 8'h01 << i);
      checkAll("R4");
    end
    cyc(8'h00, 1'b1, 1'b0, 8'hFF);
    checkAll("R4 cleanup");

    // R8: renewal refuses exactly one clear
    cyc(8'h01, 1'b0, 1'b0, 8'h00);
    cyc(8'h01, 1'b0, 1'b0, 8'h00);
    cyc(8'h00, 1'b1, 1'b0, 8'h01);
    chk("R8 refused clear keeps setup", mPend, 8'h01);
    checkAll("R8 refused");
    cyc(8'h00, 1'b1, 1'b0, 8'h01);
    chk("R8 second clear", mPend, 8'h00);
    checkAll("R8 cleared");
    // R8: other bits clear normally during a refused clear
    cyc(8'h41, 1'b0, 1'b0, 8'h00);
    cyc(8'h01, 1'b0, 1'b0, 8'h00);
    cyc(8'h00, 1'b1, 1'b0, 8'hFF);
    chk("R8 other bits clear", mPend, 8'h01);
    checkAll("R8 mixed");
    cyc(8'h00, 1'b1, 1'b0, 8'h01);
    checkAll("R8 final");
    // R8: pulse in the same cycle as the clear does not arm a renewal
    cyc(8'h01, 1'b0, 1'b0, 8'h00);
    cyc(8'h01, 1'b1, 1'b0, 8'h01);
    checkAll("R8 same-cycle set");
    cyc(8'h00, 1'b1, 1'b0, 8'h01);
    chk("R8 no renewal from same cycle", mPend, 8'h00);
    checkAll("R8 same-cycle clear");

    // R1: reset in the middle of activity
    cyc(8'hFF, 1'b1, 1'b1, 8'hFF);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    mPend = '0; mEn = '0; mRen = 1'b0;
    checkAll("R1 mid-run reset");

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule